// File: doc/BRIEF.md
# Cache Tag Invalidation Sequencer

This block drives the clear port of a cache tag array that holds 512 entries by default. When asked to invalidate the whole array, it walks the tag indices in ascending order and clears one location per clock. It raises `busy` for the whole walk so that the fetch path can hold new accesses until every location has been cleared. When the walk ends, it gives a one-cycle `done` pulse.

The cache can be built unified or split in two. In split mode, the lower half of the indices holds instruction lines and the upper half holds data lines. A request can then clear only one half, or the whole array. A single-line request clears the entry whose index is taken from address bits [12:4]. In split mode, bit 12 of that address decides whether the line sits in the instruction half or the data half. A disable input can block single-line requests.

Two requesters can start work: the core and a debug port. They share one set of operation codes. Tag comparison and line storage belong to other blocks.

Top module: `tag_inval_seq`

## Requirements
- R1: While reset is held and after it is released with no request, `busy`, `tag_clr_en` and `done` are 0.
- R2: Operation code 0 (whole array) clears indices 0 through 511 in ascending order, one per cycle. The first clear appears in the cycle after the request is sampled. `busy` and `tag_clr_en` are high for exactly those 512 cycles.
- R3: With `split_mode`=1, operation code 1 (instruction half) clears indices 0 through 255, and code 2 (data half) clears indices 256 through 511. Both run in ascending order, one per cycle, with `busy` high for 256 cycles.
- R4: With `split_mode`=0, codes 1 and 2 each behave like code 0 and clear all 512 indices.
- R5: Operation code 3 (single line) drives `tag_clr_en` for one cycle, in the cycle after the request is sampled. The index is address bits [12:4] and `busy` stays low. In split mode, address bit 12 = 0 selects a line in the instruction half and 1 selects one in the data half, because that bit is the top bit of the index.
- R6: A single-line request sampled while `push_disable`=1 clears nothing.
- R7: Requests of any kind that are sampled while `busy` is high are dropped. The walk keeps its order and length, `busy` stays high until it ends, and no clear follows it.
- R8: `done` is high for exactly one cycle, the cycle after the last clear of a walk. A single-line clear never raises it.
- R9: The debug port can start every operation that the core can. When both present a request in the same idle cycle, the core's request is carried out and the debug request is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| split_mode | input | 1 | 1 = cache split into instruction and data halves |
| push_disable | input | 1 | 1 = single-line requests are blocked |
| core_req | input | 1 | Core request valid |
| core_op | input | 2 | Core operation code (0 whole, 1 instr half, 2 data half, 3 line) |
| core_addr | input | 32 | Core line address for code 3 |
| dbg_req | input | 1 | Debug request valid |
| dbg_op | input | 2 | Debug operation code |
| dbg_addr | input | 32 | Debug line address for code 3 |
| busy | output | 1 | Walk in progress; stalls new fetches |
| tag_clr_en | output | 1 | Clear the tag at `tag_clr_idx` this cycle |
| tag_clr_idx | output | 9 | Tag index being cleared |
| done | output | 1 | One-cycle pulse after a walk ends |

## Verification
The bench targets the ends of each walk: the first and last index and the exact cycle in which `busy` falls and `done` rises. A counter off by one would clear 511 or 513 locations, or would pulse `done` while a clear is still in flight. Half-array walks are run in both split and unified mode. A wrong range decode would either sweep the wrong half in split mode or leave half of a unified array stale. Requests are injected in the middle of a walk, which catches a design that restarts the walk or queues a late clear. A single-line request sent with the disable input set, and a same-cycle collision between core and debug, check that no line is cleared against the block and that the priority rule is respected.

// File: rtl/tinv_pkg.sv
package tinv_pkg;
  typedef enum logic [1:0] {
    OP_WHOLE = 2'd0,
    OP_IHALF = 2'd1,
    OP_DHALF = 2'd2,
    OP_LINE  = 2'd3
  } inv_op_e;
endpackage

// File: rtl/tinv_arbiter.sv
module tinv_arbiter
  import tinv_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              core_req,
  input  logic [1:0]        core_op,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic              dbg_req,
  input  logic [1:0]        dbg_op,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic              sel_valid,
  output inv_op_e           sel_op,
  output logic [ADDR_W-1:0] sel_addr
);
  // Core has fixed priority over the debug port.
  always_comb begin
    sel_valid = core_req | dbg_req;
    if (core_req) begin
      sel_op   = inv_op_e'(core_op);
      sel_addr = core_addr;
    end else begin
      sel_op   = inv_op_e'(dbg_op);
      sel_addr = dbg_addr;
    end
  end
endmodule

// File: rtl/tinv_range.sv
module tinv_range
  import tinv_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  inv_op_e          op,
  input  logic             split,
  output logic [IDX_W-1:0] first,
  output logic [IDX_W-1:0] last
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int HALF  = DEPTH / 2;
  localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(DEPTH - 1);
  localparam logic [IDX_W-1:0] HALF_LO  = IDX_W'(HALF - 1);
  localparam logic [IDX_W-1:0] HALF_HI  = IDX_W'(HALF);

  function automatic logic [IDX_W-1:0] walk_first(inv_op_e o, logic s);
    if (s && o == OP_DHALF) return HALF_HI;
    return '0;
  endfunction

  function automatic logic [IDX_W-1:0] walk_last(inv_op_e o, logic s);
    if (s && o == OP_IHALF) return HALF_LO;
    return TOP_IDX;
  endfunction

  assign first = walk_first(op, split);
  assign last  = walk_last(op, split);
endmodule

// File: rtl/tinv_walker.sv
module tinv_walker #(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IDX_W-1:0] first,
  input  logic [IDX_W-1:0] last,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] end_idx,
  output logic             finish
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      idx     <= '0;
      end_idx <= '0;
    end else if (!active) begin
      if (load) begin
        active  <= 1'b1;
        idx     <= first;
        end_idx <= last;
      end
    end else if (idx == end_idx) begin
      active <= 1'b0;
    end else begin
      idx <= idx + 1'b1;
    end
  end

  assign finish = active && (idx == end_idx);
endmodule

// File: rtl/tag_inval_seq.sv
module tag_inval_seq
  import tinv_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 9,
  parameter int IDX_LSB = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              split_mode,
  input  logic              push_disable,
  input  logic              core_req,
  input  logic [1:0]        core_op,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic              dbg_req,
  input  logic [1:0]        dbg_op,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic              busy,
  output logic              tag_clr_en,
  output logic [IDX_W-1:0]  tag_clr_idx,
  output logic              done
);
  function automatic logic [IDX_W-1:0] line_index(logic [ADDR_W-1:0] a);
    return a[IDX_LSB +: IDX_W];
  endfunction

  logic              sel_valid;
  inv_op_e           sel_op;
  logic [ADDR_W-1:0] sel_addr;
  logic [IDX_W-1:0]  rng_first, rng_last;
  logic              walk_active, walk_finish;
  logic [IDX_W-1:0]  walk_idx, walk_end;

  // Named events for the checker.
  logic accept, start_walk, line_fire;
  logic line_q, done_q;
  logic [IDX_W-1:0] line_idx_q;

  tinv_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .core_req(core_req), .core_op(core_op), .core_addr(core_addr),
    .dbg_req(dbg_req), .dbg_op(dbg_op), .dbg_addr(dbg_addr),
    .sel_valid(sel_valid), .sel_op(sel_op), .sel_addr(sel_addr)
  );

  tinv_range #(.IDX_W(IDX_W)) u_rng (
    .op(sel_op), .split(split_mode), .first(rng_first), .last(rng_last)
  );

  assign accept     = sel_valid && !walk_active;
  assign start_walk = accept && (sel_op != OP_LINE);
  assign line_fire  = accept && (sel_op == OP_LINE) && !push_disable;

  tinv_walker #(.IDX_W(IDX_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(start_walk),
    .first(rng_first), .last(rng_last),
    .active(walk_active), .idx(walk_idx), .end_idx(walk_end),
    .finish(walk_finish)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q     <= 1'b0;
      line_idx_q <= '0;
      done_q     <= 1'b0;
    end else begin
      line_q     <= line_fire;
      line_idx_q <= line_index(sel_addr);
      done_q     <= walk_finish;
    end
  end

  assign busy        = walk_active;
  assign tag_clr_en  = walk_active | line_q;
  assign tag_clr_idx = walk_active ? walk_idx : line_idx_q;
  assign done        = done_q;
endmodule

// File: rtl/tag_inval_seq_chk.sv
module tag_inval_seq_chk #(
  parameter int IDX_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_disable,
  input logic             busy,
  input logic             tag_clr_en,
  input logic [IDX_W-1:0] tag_clr_idx,
  input logic             done,
  input logic [IDX_W-1:0] walk_end,
  input logic             line_fire
);
  // R2
  walk_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> tag_clr_en);
  // R2
  walk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> tag_clr_idx == $past(tag_clr_idx) + 1'b1);
  // R3
  walk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> tag_clr_idx <= walk_end);
  // R8
  done_after_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  line_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_clr_en && !busy |-> $past(line_fire));
  // R6
  line_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tag_clr_en && !busy |-> !$past(push_disable));
endmodule

bind tag_inval_seq tag_inval_seq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_disable(push_disable), .busy(busy),
  .tag_clr_en(tag_clr_en), .tag_clr_idx(tag_clr_idx), .done(done),
  .walk_end(walk_end), .line_fire(line_fire)
);

// File: tb/tag_inval_seq_tb.sv
module tag_inval_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        split_mode = 1'b0, push_disable = 1'b0;
  logic        core_req = 1'b0, dbg_req = 1'b0;
  logic [1:0]  core_op = 2'd0, dbg_op = 2'd0;
  logic [31:0] core_addr = '0, dbg_addr = '0;
  logic        busy, tag_clr_en, done;
  logic [8:0]  tag_clr_idx;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  tag_inval_seq u_dut (
    .clk(clk), .rst_n(rst_n), .split_mode(split_mode), .push_disable(push_disable),
    .core_req(core_req), .core_op(core_op), .core_addr(core_addr),
    .dbg_req(dbg_req), .dbg_op(dbg_op), .dbg_addr(dbg_addr),
    .busy(busy), .tag_clr_en(tag_clr_en), .tag_clr_idx(tag_clr_idx), .done(done)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic idle_check(input string rq);
    check(!busy && !tag_clr_en && !done, rq,
          {busy, tag_clr_en, done}, 0);
  endtask

  // Issue a walk and follow it; optionally inject requests mid-walk.
  task automatic run_walk(input bit use_dbg, input logic [1:0] op, input bit split,
                          input int first, input int n, input string rq, input bit inject);
    int bad = -1;
    int bad_idx = 0;
    split_mode = split;
    if (use_dbg) begin dbg_req = 1'b1; dbg_op = op; end
    else begin core_req = 1'b1; core_op = op; end
    @(negedge clk);
    core_req = 1'b0; dbg_req = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (inject && i == 10) begin
        core_req = 1'b1; core_op = 2'd3; core_addr = 32'h0000_0050;
        dbg_req = 1'b1; dbg_op = 2'd1;
      end
      if (inject && i == 14) begin core_req = 1'b0; dbg_req = 1'b0; end
      if (bad < 0 && !(busy && tag_clr_en && !done && tag_clr_idx == 9'(first + i))) begin
        bad = i; bad_idx = tag_clr_idx;
      end
      @(negedge clk);
    end
    check(bad < 0, rq, bad_idx, first + (bad < 0 ? 0 : bad));
    check(done && !busy && !tag_clr_en, {rq, "/R8 done"}, {done, busy, tag_clr_en}, 3'b100);
    @(negedge clk);
    idle_check({rq, "/R8 done falls"});
    @(negedge clk);
    idle_check({rq, "/R7 nothing after walk"});
  endtask

  task automatic run_line(input bit use_dbg, input logic [31:0] addr, input bit dis,
                          input string rq);
    push_disable = dis;
    if (use_dbg) begin dbg_req = 1'b1; dbg_op = 2'd3; dbg_addr = addr; end
    else begin core_req = 1'b1; core_op = 2'd3; core_addr = addr; end
    @(negedge clk);
    core_req = 1'b0; dbg_req = 1'b0; push_disable = 1'b0;
    if (dis) check(!tag_clr_en && !busy, rq, tag_clr_en, 0);
    else check(tag_clr_en && !busy && !done && tag_clr_idx == 9'((addr >> 4) & 32'h1FF),
               rq, tag_clr_idx, int'((addr >> 4) & 32'h1FF));
    @(negedge clk);
    idle_check({rq, "/R8 no done after line"});
  endtask

  task automatic run_collision();
    core_req = 1'b1; core_op = 2'd3; core_addr = 32'h0000_0040;
    dbg_req = 1'b1; dbg_op = 2'd3; dbg_addr = 32'h0000_0080;
    @(negedge clk);
    core_req = 1'b0; dbg_req = 1'b0;
    check(tag_clr_en && tag_clr_idx == 9'd4, "R9 core wins", tag_clr_idx, 4);
    @(negedge clk);
    idle_check("R9 debug dropped");
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_check("R1 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    idle_check("R1 after reset");
    run_walk(1'b0, 2'd0, 1'b0, 0, 512, "R2 whole unified", 1'b0);
    run_walk(1'b0, 2'd1, 1'b1, 0, 256, "R3 instr half", 1'b0);
    run_walk(1'b1, 2'd2, 1'b1, 256, 256, "R3 R9 data half via debug", 1'b0);
    run_walk(1'b0, 2'd2, 1'b0, 0, 512, "R4 data code unified", 1'b0);
    run_walk(1'b0, 2'd0, 1'b1, 0, 512, "R7 inject during walk", 1'b1);
    run_line(1'b0, 32'h0000_1A30, 1'b0, "R5 line data half");
    split_mode = 1'b1;
    run_line(1'b1, 32'h0000_0FF0, 1'b0, "R5 R9 line instr half via debug");
    run_line(1'b0, 32'h0000_1A30, 1'b1, "R6 line blocked");
    run_collision();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule